// File: doc/BRIEF.md
# Dual-Channel Window Watchdog Comparator

This block sits beside an analog-to-digital converter. It watches the stream of converted results and checks two channels against a programmable voltage window. A 4-bit select field picks the channel for watchdog A. Watchdog B always guards the next channel up, and above channel 15 it wraps to channel 0. Each watchdog has an upper and a lower threshold. A result counts as inside the window when it is greater than or equal to the lower threshold and strictly less than the upper threshold. Any other result on a guarded channel sets a sticky flag for that threshold and raises a request flag.

Software programs each 10-bit threshold through two byte writes. The first write stages the eight most significant bits. The second write supplies the two least significant bits in its top two bit positions and commits the whole value. Software acknowledges the request with a one-cycle pulse. The acknowledge clears the request flag and all four threshold flags together. The interrupt output is the request flag gated by a mask bit.

The result input is a valid/ready stream. The block never applies back-pressure: ready stays high, and every cycle with valid high delivers exactly one result.

Top module: `wdg_window_monitor`

## Requirements
- R1: `res_ready` is 1 in every cycle after reset, and every cycle with `res_valid` high is evaluated as one result.
- R2: Watchdog A monitors channel `chan_sel`. Watchdog B monitors channel `(chan_sel+1) mod 16`, so a select value of 15 makes B monitor channel 0. Results on any other channel leave every flag unchanged.
- R3: A result with lower <= value < upper sets no flag. A value equal to the lower threshold is inside the window.
- R4: A guarded result with value >= upper sets that watchdog's upper flag on the next clock edge. The A upper flag is `crr[7]` and the B upper flag is `crr[5]`.
- R5: A guarded result with value < lower sets that watchdog's lower flag on the next clock edge. The A lower flag is `crr[6]` and the B lower flag is `crr[4]`.
- R6: `crr[3:0]` always reads 0. The flags are sticky: they accumulate until an acknowledge clears them.
- R7: After reset, all flags and `wdg_req` are 0. Every upper threshold is 1023 and every lower threshold is 0.
- R8: On a write, `wr_addr[2:1]` selects the threshold (0 = A upper, 1 = A lower, 2 = B upper, 3 = B lower). With `wr_addr[0]=0` the write stages value bits 9:2 from `wr_data[7:0]`, and the threshold in use does not change. With `wr_addr[0]=1` the write commits the staged bits together with value bits 1:0 taken from `wr_data[7:6]`.
- R9: Any flag being set also sets `wdg_req` on the same edge. `wdg_req` then stays set until it is acknowledged.
- R10: A `req_ack` pulse clears `wdg_req` and all flags on the next edge. An out-of-window result arriving in the same cycle as the acknowledge wins: its flag and the request are set.
- R11: `irq` is high exactly when `wdg_req` is high and `irq_mask` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Conversion result valid |
| res_ready | output | 1 | Always 1; no back-pressure |
| res_chan | input | 4 | Channel number of the result |
| res_data | input | 10 | Converted value |
| chan_sel | input | 4 | Channel for watchdog A; B uses the next channel |
| wr_en | input | 1 | Threshold byte write strobe |
| wr_addr | input | 3 | Threshold index [2:1], byte select [0] |
| wr_data | input | 8 | Threshold byte |
| req_ack | input | 1 | Software acknowledge; clears request and flags |
| irq_mask | input | 1 | Interrupt enable |
| crr | output | 8 | Compare results: flags in [7:4], zeros in [3:0] |
| wdg_req | output | 1 | Watchdog request flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with its default parameters: 10-bit results, 16 channels and byte-wide register writes. With these values every threshold edge can be reached exactly, including a value equal to an upper or a lower limit, and the full-scale value 1023 can be checked against the reset thresholds. The 4-bit select covers the wrap from channel 15 to channel 0. A vector table covers the window edges, results on unguarded channels and an acknowledge that arrives together with a new event. Directed tests then cover the reset state, the wrap, committing a threshold only on its second byte, and the mask.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    TH_A_UP = 2'd0,
    TH_A_LO = 2'd1,
    TH_B_UP = 2'd2,
    TH_B_LO = 2'd3
  } thr_idx_e;

  localparam int NUM_THR = 4;
  localparam int NUM_WDG = 2;
endpackage

// File: rtl/wdg_thresh_reg.sv
module wdg_thresh_reg #(
  parameter int DATA_W = 10,
  parameter int REG_W  = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [REG_W-1:0]  wr_data,
  output logic [DATA_W-1:0] thr
);
  localparam int LO_BITS = DATA_W - REG_W;

  logic [REG_W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= RST_VAL[DATA_W-1 -: REG_W];
      thr    <= RST_VAL;
    end else begin
      if (wr_hi) hold_q <= wr_data;
      if (wr_lo) thr    <= {hold_q, wr_data[REG_W-1 -: LO_BITS]};
    end
  end
endmodule

// File: rtl/wdg_window_cmp.sv
module wdg_window_cmp #(
  parameter int DATA_W = 10
) (
  input  logic              sel,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] upper,
  input  logic [DATA_W-1:0] lower,
  output logic              hit_up,
  output logic              hit_lo
);
  always_comb begin
    hit_up = sel && (value >= upper);
    hit_lo = sel && (value <  lower);
  end
endmodule

// File: rtl/wdg_window_monitor.sv
module wdg_window_monitor #(
  parameter int DATA_W = 10,
  parameter int CH_W   = 4,
  parameter int REG_W  = 8,
  parameter int CRR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              req_ack,
  input  logic              irq_mask,
  output logic [CRR_W-1:0]  crr,
  output logic              wdg_req,
  output logic              irq
);
  import wdg_pkg::*;

  localparam int FLAG_W = NUM_THR;
  localparam int PAD_W  = CRR_W - FLAG_W;

  logic [DATA_W-1:0] thr [NUM_THR];
  logic [FLAG_W-1:0] hits;
  logic [FLAG_W-1:0] flags_q;
  logic [CH_W-1:0]   chan_b;
  logic              req_q;

  assign res_ready = 1'b1;
  assign chan_b    = chan_sel + 1'b1;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    localparam logic [DATA_W-1:0] RV = (t % 2 == 0) ? {DATA_W{1'b1}} : '0;
    wdg_thresh_reg #(.DATA_W(DATA_W), .REG_W(REG_W), .RST_VAL(RV)) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (wr_en && wr_addr[2:1] == t[1:0] && !wr_addr[0]),
      .wr_lo   (wr_en && wr_addr[2:1] == t[1:0] &&  wr_addr[0]),
      .wr_data (wr_data),
      .thr     (thr[t])
    );
  end

  // Flag bit positions: A upper=3, A lower=2, B upper=1, B lower=0
  for (genvar w = 0; w < NUM_WDG; w++) begin : g_wdg
    logic hu, hl;
    wdg_window_cmp #(.DATA_W(DATA_W)) u_cmp (
      .sel    (res_valid && res_chan == ((w == 0) ? chan_sel : chan_b)),
      .value  (res_data),
      .upper  (thr[2*w]),
      .lower  (thr[2*w+1]),
      .hit_up (hu),
      .hit_lo (hl)
    );
    assign hits[FLAG_W-1-2*w] = hu;
    assign hits[FLAG_W-2-2*w] = hl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      req_q   <= 1'b0;
    end else begin
      flags_q <= (req_ack ? '0 : flags_q) | hits;
      req_q   <= (req_ack ? 1'b0 : req_q) | (|hits);
    end
  end

  assign crr     = {flags_q, {PAD_W{1'b0}}};
  assign wdg_req = req_q;
  assign irq     = req_q & irq_mask;
endmodule

// File: rtl/wdg_window_monitor_chk.sv
module wdg_window_monitor_chk #(
  parameter int CH_W  = 4,
  parameter int CRR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             res_valid,
  input logic             res_ready,
  input logic [CH_W-1:0]  res_chan,
  input logic [CH_W-1:0]  chan_sel,
  input logic             req_ack,
  input logic             irq_mask,
  input logic [CRR_W-1:0] crr,
  input logic             wdg_req,
  input logic             irq
);
  logic [CH_W-1:0] nxt_ch;
  logic            guarded;
  assign nxt_ch  = chan_sel + 1'b1;
  assign guarded = res_valid && (res_chan == chan_sel || res_chan == nxt_ch);

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n) res_ready); // R1
  AST_OTHER_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (!guarded && !req_ack) |=> $stable(crr)); // R2
  AST_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) crr[3:0] == 4'd0); // R6
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ack |=> ((crr & $past(crr)) == $past(crr))); // R6
  AST_FLAG_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|crr[CRR_W-1 -: 4]) |-> wdg_req); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_req && !req_ack) |=> wdg_req); // R9
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && !res_valid) |=> (crr == '0 && !wdg_req)); // R10
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask |-> !irq); // R11
endmodule

bind wdg_window_monitor wdg_window_monitor_chk #(.CH_W(CH_W), .CRR_W(CRR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .res_chan(res_chan), .chan_sel(chan_sel), .req_ack(req_ack),
  .irq_mask(irq_mask), .crr(crr), .wdg_req(wdg_req), .irq(irq)
);

// File: tb/wdg_window_monitor_tb.sv
module wdg_window_monitor_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       res_valid = 0;
  logic       res_ready;
  logic [3:0] res_chan = 0;
  logic [9:0] res_data = 0;
  logic [3:0] chan_sel = 0;
  logic       wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic       req_ack = 0;
  logic       irq_mask = 0;
  logic [7:0] crr;
  logic       wdg_req;
  logic       irq;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  wdg_window_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .chan_sel(chan_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .req_ack(req_ack),
    .irq_mask(irq_mask), .crr(crr), .wdg_req(wdg_req), .irq(irq)
  );

  // {valid, ack, chan[4], data[10], flags[4] (AU,AL,BU,BL), req}; A on ch3, B on ch4
  localparam int NV = 11;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd3, 10'd300,  4'b0000, 1'b0},  // R3 inside
    {1'b1, 1'b0, 4'd3, 10'd200,  4'b0000, 1'b0},  // R3 equal lower
    {1'b1, 1'b0, 4'd3, 10'd599,  4'b0000, 1'b0},  // R3 just below upper
    {1'b1, 1'b0, 4'd3, 10'd600,  4'b1000, 1'b1},  // R4 equal upper
    {1'b1, 1'b0, 4'd5, 10'd1023, 4'b1000, 1'b1},  // R2 other channel
    {1'b1, 1'b0, 4'd4, 10'd100,  4'b1000, 1'b1},  // R3 B equal lower
    {1'b1, 1'b0, 4'd4, 10'd99,   4'b1001, 1'b1},  // R5 B below lower
    {1'b0, 1'b1, 4'd4, 10'd0,    4'b0000, 1'b0},  // R10 ack clears
    {1'b1, 1'b0, 4'd3, 10'd199,  4'b0100, 1'b1},  // R5 A below lower
    {1'b1, 1'b0, 4'd4, 10'd900,  4'b0110, 1'b1},  // R4 B equal upper, R6 sticky
    {1'b1, 1'b1, 4'd3, 10'd1000, 4'b1000, 1'b1}   // R10 event wins over ack
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_thr(input logic [1:0] idx, input logic [9:0] v, input bit commit);
    @(negedge clk);
    wr_en = 1; wr_addr = {idx, 1'b0}; wr_data = v[9:2];
    if (commit) begin
      @(negedge clk);
      wr_addr = {idx, 1'b1}; wr_data = {v[1:0], 6'b0};
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic step(input logic v, input logic a, input logic [3:0] ch, input logic [9:0] d);
    @(negedge clk);
    res_valid = v; req_ack = a; res_chan = ch; res_data = d;
    @(negedge clk);
    res_valid = 0; req_ack = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state, R1 ready
    chk("R7 crr", crr, 0);
    chk("R7 req", wdg_req, 0);
    chk("R1 ready", res_ready, 1);
    // R7 reset thresholds on A=ch0: 1023 out, 0 in
    step(1, 0, 4'd0, 10'd0);
    chk("R7 lower 0", crr, 0);
    step(1, 0, 4'd0, 10'd1023);
    chk("R7 upper 1023", crr, 8'h80);
    step(0, 1, 4'd0, 10'd0);
    chk("R10 ack", crr, 0);

    chan_sel = 4'd3;
    wr_thr(2'd0, 10'd600, 1);
    wr_thr(2'd1, 10'd200, 1);
    wr_thr(2'd2, 10'd900, 1);
    wr_thr(2'd3, 10'd100, 1);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][20], VEC[i][19], VEC[i][18:15], VEC[i][14:5]);
      chk($sformatf("R2-R10 vec%0d crr", i), crr, {VEC[i][4:1], 4'b0});
      chk($sformatf("R9 vec%0d req", i), wdg_req, VEC[i][0]);
    end

    // R11 mask
    irq_mask = 0; #1;
    chk("R11 masked", irq, 0);
    irq_mask = 1; #1;
    chk("R11 unmasked", irq, 1);
    step(0, 1, 4'd0, 10'd0);
    chk("R11 after ack", irq, 0);
    irq_mask = 0;

    // R2 wrap: sel 15 -> B on ch0
    chan_sel = 4'd15;
    step(1, 0, 4'd0, 10'd99);
    chk("R2 wrap B lower", crr, 8'h10);
    step(1, 0, 4'd15, 10'd650);
    chk("R2 A on ch15", crr, 8'h90);
    step(0, 1, 4'd0, 10'd0);

    // R8 commit only on low byte: A upper staged to 801
    wr_thr(2'd0, 10'd801, 0);
    step(1, 0, 4'd15, 10'd700);
    chk("R8 staged not used", crr, 8'h80);
    step(0, 1, 4'd0, 10'd0);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'b001; wr_data = 8'b0100_0000;
    @(negedge clk);
    wr_en = 0;
    step(1, 0, 4'd15, 10'd800);
    chk("R8 committed 800 in", crr, 0);
    step(1, 0, 4'd15, 10'd801);
    chk("R8 committed 801 out", crr, 8'h80);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule